// File: doc/BRIEF.md
# I2C Channel-Select Switch Controller

This block is the digital control side of an eight-way I2C bus switch. It behaves as an I2C slave with one 8-bit selection register. Its outputs are eight channel-enable signals that drive the downstream pass gates. A single fast system clock samples SCL and SDA through two-flop synchronizers. On the synchronized lines the block detects START and STOP, matches its 7-bit address, and acknowledges. SDA is driven only through an open-drain pull-down enable.

A selection byte written by the master is first held as pending. It reaches the channel outputs at the STOP that closes the bus transaction, when all lines are idle high. A read returns the selection that is currently applied. The active-low reset clears the selection, drops every channel and returns the protocol engine to idle. The block leaves reset with every channel off.

Top module: `i2c_chan_switch`

## Requirements
- R1: The block answers to the 7-bit address made of the fixed upper bits 1110 followed by pins addr_pins[2], addr_pins[1] and addr_pins[0], with addr_pins[0] as the least significant bit. The eighth bit is the direction (1 = read, 0 = write). On a match the block pulls SDA low during the ninth clock pulse.
- R2: An address that does not match gets no acknowledge. The block then ignores the bus until the next START or STOP, and a write sent to another address leaves the channel outputs unchanged.
- R3: In a write, every data byte is acknowledged. When several bytes arrive in one transaction, only the last one becomes the new selection.
- R4: Bit n of the selection drives chan_en[n]. Every combination is allowed, including all channels off (0x00) and all on (0xFF).
- R5: A written byte does not change chan_en before a STOP. It appears on chan_en only after the STOP.
- R6: A read shifts out the applied selection, most significant bit first. A byte that is still pending is not visible to a read. Each byte the master acknowledges is followed by another copy of the selection.
- R7: When the master does not acknowledge a read byte, the block leaves SDA released so the master can issue STOP.
- R8: While rst_n is low, chan_en is 0 and SDA is released. A pending byte is discarded, and after reset the block waits for a new START.
- R9: A repeated START at any point restarts address reception. A pending byte from a write that was cut short by a repeated START is kept, and it is applied at the STOP that finally ends the transaction.
- R10: SDA is released after the falling SCL edge that ends an acknowledge slot. The pull-down changes only after a falling SCL edge, a START or a STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low reset, asynchronous |
| addr_pins | input | 3 | Low three bits of the slave address |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| chan_en | output | 8 | Channel-enable vector, bit n for channel n |

## Verification
The hardest situation to reach is a write whose pending byte must survive a repeated START and a following read, and only then take effect. The stimulus writes a byte, issues a repeated START without a STOP, and reads. It checks that the read returns the old selection and that the channels stay put, then closes with STOP and looks for the new value. An address phase cut short after four bits by another START, and a reset pulse in the middle of an acknowledged write, reach the other paths that leave a transaction early.

// File: rtl/i2c_sw_pkg.sv
`timescale 1ns/1ps
package i2c_sw_pkg;
    localparam int BYTE_W   = 8;
    localparam int CH_N     = 8;
    localparam int PIN_W    = 3;
    localparam int CNT_W    = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_WDAT,
        ST_WACK,
        ST_RDAT,
        ST_RACK
    } sw_state_e;

    typedef struct packed {
        sw_state_e          state;
        logic [CNT_W-1:0]   cnt;
        logic [BYTE_W-1:0]  rx;
        logic [BYTE_W-1:0]  tx;
        logic               rd;
        logic               m_ack;
        logic               oe;
        logic [CH_N-1:0]    pend;
        logic [CH_N-1:0]    act;
    } sw_regs_t;
endpackage

// File: rtl/i2c_sw_sync.sv
`timescale 1ns/1ps
module i2c_sw_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] in_async,
    output logic [WIDTH-1:0] out_sync
);
    logic [WIDTH-1:0] stage_q [STAGES];
    logic [WIDTH-1:0] stage_d [STAGES];

    always_comb begin
        stage_d[0] = in_async;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    // Idle bus lines are high, so reset to ones.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '1;
        end else begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= stage_d[i];
        end
    end

    assign out_sync = stage_q[STAGES-1];
endmodule

// File: rtl/i2c_sw_cond.sv
`timescale 1ns/1ps
module i2c_sw_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    typedef struct packed {
        logic scl;
        logic sda;
    } prev_t;

    prev_t prev_d, prev_q;

    always_comb begin
        prev_d.scl = scl_s;
        prev_d.sda = sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= prev_d;
    end

    assign scl_rise  = scl_s & ~prev_q.scl;
    assign scl_fall  = ~scl_s & prev_q.scl;
    assign start_det = scl_s & prev_q.scl & prev_q.sda & ~sda_s;
    assign stop_det  = scl_s & prev_q.scl & ~prev_q.sda & sda_s;
endmodule

// File: rtl/i2c_sw_fsm.sv
`timescale 1ns/1ps
module i2c_sw_fsm
    import i2c_sw_pkg::*;
#(
    parameter logic [3:0] ADDR_HI = 4'b1110
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIN_W-1:0] addr_pins,
    input  logic             sda_s,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    output logic             sda_oe,
    output logic [CH_N-1:0]  chan_en
);
    sw_regs_t r_d, r_q;
    logic     addr_hit;

    assign addr_hit = (r_q.rx[BYTE_W-1:1] == {ADDR_HI, addr_pins});

    always_comb begin
        r_d = r_q;
        if (start_det) begin
            r_d.state = ST_ADDR;
            r_d.cnt   = '0;
            r_d.oe    = 1'b0;
        end else if (stop_det) begin
            r_d.state = ST_IDLE;
            r_d.oe    = 1'b0;
            r_d.act   = r_q.pend;
        end else begin
            unique case (r_q.state)
                ST_IDLE: ;
                ST_ADDR, ST_WDAT: begin
                    if (scl_rise) begin
                        r_d.rx  = {r_q.rx[BYTE_W-2:0], sda_s};
                        r_d.cnt = r_q.cnt + 1'b1;
                    end else if (scl_fall && r_q.cnt == LAST_BIT) begin
                        if (r_q.state == ST_ADDR) begin
                            if (addr_hit) begin
                                r_d.oe    = 1'b1;
                                r_d.rd    = r_q.rx[0];
                                r_d.state = ST_AACK;
                            end else begin
                                r_d.state = ST_IDLE;
                            end
                        end else begin
                            r_d.oe    = 1'b1;
                            r_d.pend  = r_q.rx;
                            r_d.state = ST_WACK;
                        end
                    end
                end
                ST_AACK, ST_WACK: begin
                    if (scl_fall) begin
                        r_d.cnt = '0;
                        if (r_q.state == ST_AACK && r_q.rd) begin
                            r_d.oe    = ~r_q.act[BYTE_W-1];
                            r_d.tx    = {r_q.act[BYTE_W-2:0], 1'b0};
                            r_d.state = ST_RDAT;
                        end else begin
                            r_d.oe    = 1'b0;
                            r_d.state = ST_WDAT;
                        end
                    end
                end
                ST_RDAT: begin
                    if (scl_rise) begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end else if (scl_fall) begin
                        if (r_q.cnt == LAST_BIT) begin
                            r_d.oe    = 1'b0;
                            r_d.state = ST_RACK;
                        end else begin
                            r_d.oe = ~r_q.tx[BYTE_W-1];
                            r_d.tx = {r_q.tx[BYTE_W-2:0], 1'b0};
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        r_d.m_ack = ~sda_s;
                    end else if (scl_fall) begin
                        r_d.cnt = '0;
                        if (r_q.m_ack) begin
                            r_d.oe    = ~r_q.act[BYTE_W-1];
                            r_d.tx    = {r_q.act[BYTE_W-2:0], 1'b0};
                            r_d.state = ST_RDAT;
                        end else begin
                            r_d.state = ST_IDLE;
                        end
                    end
                end
                default: r_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign sda_oe  = r_q.oe;
    assign chan_en = r_q.act;
endmodule

// File: rtl/i2c_chan_switch.sv
`timescale 1ns/1ps
module i2c_chan_switch
    import i2c_sw_pkg::*;
#(
    parameter logic [3:0] ADDR_HI     = 4'b1110,
    parameter int         SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIN_W-1:0] addr_pins,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe,
    output logic [CH_N-1:0]  chan_en
);
    logic [1:0] line_s;
    logic       scl_rise, scl_fall, start_det, stop_det;

    i2c_sw_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_async ({scl_i, sda_i}),
        .out_sync (line_s)
    );

    i2c_sw_cond u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (line_s[1]),
        .sda_s     (line_s[0]),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_sw_fsm #(.ADDR_HI(ADDR_HI)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_pins (addr_pins),
        .sda_s     (line_s[0]),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_oe    (sda_oe),
        .chan_en   (chan_en)
    );
endmodule

// File: rtl/i2c_chan_switch_chk.sv
`timescale 1ns/1ps
module i2c_chan_switch_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] chan_en,
    input logic       sda_oe,
    input logic       scl_fall,
    input logic       start_det,
    input logic       stop_det
);
    // R5
    chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(chan_en) |-> $past(stop_det));

    // R8
    rst_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (chan_en == 8'h00 && !sda_oe));

    // R10
    oe_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> $past(scl_fall || start_det || stop_det));

    // R9
    start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_oe);
endmodule

bind i2c_chan_switch i2c_chan_switch_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .chan_en   (chan_en),
    .sda_oe    (sda_oe),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
);

// File: tb/i2c_chan_switch_tb.sv
`timescale 1ns/1ps
module i2c_chan_switch_tb;
    localparam realtime QT = 50ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] addr_pins = 3'b101;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       sda_oe;
    logic [7:0] chan_en;
    logic       sda_bus;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        string       req;
        logic [31:0] val;
    } item_t;

    item_t exp_q[$];
    logic [31:0] obs_q[$];

    assign sda_bus = m_sda & ~sda_oe;

    always #2.5ns clk = ~clk;

    i2c_chan_switch u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_pins (addr_pins),
        .scl_i     (m_scl),
        .sda_i     (sda_bus),
        .sda_oe    (sda_oe),
        .chan_en   (chan_en)
    );

    task automatic expect_val(input string req, input logic [31:0] e, input logic [31:0] o);
        item_t it;
        it.req = req;
        it.val = e;
        exp_q.push_back(it);
        obs_q.push_back(o);
    endtask

    // Monitor: pops expected/observed pairs and compares them.
    initial begin
        forever begin
            @(negedge clk);
            while (obs_q.size() > 0 && exp_q.size() > 0) begin
                item_t it;
                logic [31:0] o;
                it = exp_q.pop_front();
                o  = obs_q.pop_front();
                checks++;
                if (o !== it.val) begin
                    errors++;
                    $display("FAIL %s actual=%0h expected=%0h", it.req, o, it.val);
                end
            end
        end
    end

    task automatic bus_start();
        m_sda = 1'b1; #QT;
        m_scl = 1'b1; #QT;
        m_sda = 1'b0; #QT;
        m_scl = 1'b0; #QT;
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; #QT;
        m_scl = 1'b1; #QT;
        m_sda = 1'b1; #QT;
        #QT;
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            m_sda = b[i]; #QT;
            m_scl = 1'b1; #(2*QT);
            m_scl = 1'b0; #QT;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack, output logic oe_after);
        send_bits(b, 8);
        m_sda = 1'b1; #QT;
        m_scl = 1'b1; #QT;
        ack = sda_bus; #QT;
        m_scl = 1'b0; #QT;
        oe_after = sda_oe;
    endtask

    task automatic read_byte(input logic nack, output logic [7:0] d);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            #QT; m_scl = 1'b1; #QT;
            d[i] = sda_bus; #QT;
            m_scl = 1'b0;
        end
        #QT;
        m_sda = nack; #QT;
        m_scl = 1'b1; #(2*QT);
        m_scl = 1'b0; #QT;
        m_sda = 1'b1;
    endtask

    task automatic settle();
        repeat (20) @(negedge clk);
    endtask

    task automatic write_txn(input logic [6:0] a, input logic [7:0] data);
        logic ack, oe;
        bus_start();
        send_byte({a, 1'b0}, ack, oe);
        send_byte(data, ack, oe);
        bus_stop();
        settle();
    endtask

    localparam logic [6:0] MY_ADDR = 7'b1110101;

    initial begin
        logic ack, oe;
        logic [7:0] d;
        repeat (10) @(negedge clk);
        // R8: reset state
        expect_val("R8 reset chan_en", 32'h0, chan_en);
        expect_val("R8 reset sda_oe", 32'h0, sda_oe);
        rst_n = 1'b1;
        settle();

        // R1, R10, R3, R5, R4: single write
        bus_start();
        send_byte({MY_ADDR, 1'b0}, ack, oe);
        expect_val("R1 address ack", 32'h0, ack);
        expect_val("R10 release after address ack", 32'h0, oe);
        send_byte(8'h5A, ack, oe);
        expect_val("R3 data ack", 32'h0, ack);
        expect_val("R10 release after data ack", 32'h0, oe);
        settle();
        expect_val("R5 no change before stop", 32'h0, chan_en);
        bus_stop();
        settle();
        expect_val("R4 R5 applied at stop", 32'h5A, chan_en);

        // R6, R7: read with master ack then nack
        bus_start();
        send_byte({MY_ADDR, 1'b1}, ack, oe);
        expect_val("R1 read address ack", 32'h0, ack);
        read_byte(1'b0, d);
        expect_val("R6 read first byte", 32'h5A, d);
        read_byte(1'b1, d);
        expect_val("R6 read repeated byte", 32'h5A, d);
        expect_val("R7 sda released after nack", 32'h0, sda_oe);
        expect_val("R7 bus high after nack", 32'h1, sda_bus);
        bus_stop();
        settle();
        expect_val("R6 read leaves channels", 32'h5A, chan_en);

        // R3: multi-byte write keeps last
        bus_start();
        send_byte({MY_ADDR, 1'b0}, ack, oe);
        send_byte(8'h11, ack, oe);
        expect_val("R3 multi byte1 ack", 32'h0, ack);
        send_byte(8'h22, ack, oe);
        expect_val("R3 multi byte2 ack", 32'h0, ack);
        send_byte(8'hC3, ack, oe);
        expect_val("R3 multi byte3 ack", 32'h0, ack);
        bus_stop();
        settle();
        expect_val("R3 last byte kept", 32'hC3, chan_en);

        // R4: all on, all off
        write_txn(MY_ADDR, 8'hFF);
        expect_val("R4 all channels", 32'hFF, chan_en);
        write_txn(MY_ADDR, 8'h00);
        expect_val("R4 no channels", 32'h00, chan_en);
        write_txn(MY_ADDR, 8'h4C);
        expect_val("R4 mixed channels", 32'h4C, chan_en);

        // R2: wrong address ignored
        bus_start();
        send_byte({7'b1110100, 1'b0}, ack, oe);
        expect_val("R2 no ack on mismatch", 32'h1, ack);
        send_byte(8'h99, ack, oe);
        expect_val("R2 data not acked", 32'h1, ack);
        bus_stop();
        settle();
        expect_val("R2 channels unchanged", 32'h4C, chan_en);

        // R9, R6: pending survives repeated start and a read
        bus_start();
        send_byte({MY_ADDR, 1'b0}, ack, oe);
        send_byte(8'h3C, ack, oe);
        bus_start();
        send_byte({MY_ADDR, 1'b1}, ack, oe);
        expect_val("R9 ack after repeated start", 32'h0, ack);
        read_byte(1'b1, d);
        expect_val("R6 pending not visible", 32'h4C, d);
        expect_val("R9 channels held before stop", 32'h4C, chan_en);
        bus_stop();
        settle();
        expect_val("R9 pending applied at final stop", 32'h3C, chan_en);

        // R9: repeated start inside address phase
        bus_start();
        send_bits(8'hE0, 4);
        bus_start();
        send_byte({MY_ADDR, 1'b0}, ack, oe);
        expect_val("R9 address restarted", 32'h0, ack);
        send_byte(8'h81, ack, oe);
        bus_stop();
        settle();
        expect_val("R9 write after restart", 32'h81, chan_en);

        // R8: reset during a write
        bus_start();
        send_byte({MY_ADDR, 1'b0}, ack, oe);
        send_byte(8'h77, ack, oe);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        expect_val("R8 reset clears channels", 32'h0, chan_en);
        expect_val("R8 reset releases sda", 32'h0, sda_oe);
        rst_n = 1'b1;
        bus_stop();
        settle();
        expect_val("R8 pending discarded", 32'h0, chan_en);

        repeat (5) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule